// File: doc/BRIEF.md
# Per-Pin Mode-Selectable GPIO Port

This block manages one general-purpose I/O port of `WIDTH` pins (eight by default). Software writes three registers: an output data latch and two mode registers, the first and second mode selectors. Bit `i` of the two mode registers together picks the drive mode of pin `i`. There are four modes: quasi-bidirectional, push-pull, high-impedance input and open-drain. From the mode and the latch bit, the block computes three per-pin pad controls: strong-drive enable, drive value and weak pull-up enable.

The default modes after reset come from a tristate fuse input and a parameter mask of analog-capable pins. The fuse input is sampled while reset is held. During power-down the block turns off the input buffer of every pin, and a disabled pin reads as 1. Two kinds of pin are exempt: pins in a parameter mask of wake-up sources, and pins that the interrupt logic flags as general-purpose interrupt inputs. Each pin level passes through a two-flop synchronizer before it can be read.

Top module: `gpio_mode_port`

## Requirements
- R1: Pin mode is {first selector bit, second selector bit}. In quasi-bidirectional mode (00), a latch 1 sets only `pullup_en` with `drive_en` low, and a latch 0 sets `drive_en` with `drive_val` 0 and `pullup_en` low.
- R2: In push-pull mode (01), `drive_en` is 1, `drive_val` equals the latch bit and `pullup_en` is 0.
- R3: In input-only mode (10), `drive_en` and `pullup_en` are both 0.
- R4: In open-drain mode (11), `drive_en` is the inverse of the latch bit (driving 0), and `pullup_en` is 0.
- R5: Each pin's mode comes only from its own bit of the two selector registers, so mixed modes can coexist within the port.
- R6: With `fuse_tristate` high during reset, every pin comes out of reset in input-only mode (first selector reads all ones, second reads zero).
- R7: With `fuse_tristate` low during reset, pins outside `ANALOG_MASK` (default 0xF0) come out of reset in quasi-bidirectional mode, and pins inside it come out in input-only mode.
- R8: The data latch resets to all ones. Register select 0 is the data latch, 1 is the first selector and 2 is the second selector. Each reads back its last written value, and a write with select 3 changes none of them.
- R9: Read select 3 and `pin_level` return the pin input after two flip-flop stages: it is unchanged one clock edge after the input changes and updated after the second. The value is independent of the latch.
- R10: While `pwr_down` is high, `in_buf_en` is low for the gated pins, and these pins read as 1 once two edges have passed.
- R11: During power-down, pins in `WAKE_MASK` (default 0x0C) and pins with `irq_pin_en` set keep `in_buf_en` high and keep reading the true level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_tristate | input | 1 | Tristate fuse; selects reset-time default modes |
| pwr_down | input | 1 | Power-down state; gates input buffers |
| irq_pin_en | input | WIDTH | Per-pin flag: pin serves as a general-purpose interrupt input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 latch, 1 first selector, 2 second selector |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Read source: 0 latch, 1 first selector, 2 second selector, 3 pin level |
| rd_data | output | WIDTH | Read data |
| pin_in | input | WIDTH | Raw pad input levels |
| drive_en | output | WIDTH | Strong-drive enable per pin |
| drive_val | output | WIDTH | Drive value per pin |
| pullup_en | output | WIDTH | Weak pull-up enable per pin |
| in_buf_en | output | WIDTH | Input buffer enable per pin |
| pin_level | output | WIDTH | Synchronized, gated pin level |

## Verification
The bench resets the block with the fuse both high and low. A design that ignored the fuse, or ignored the analog mask, would read back the wrong selector defaults and turn on pull-ups on analog pins. One mixed configuration puts all four modes in a single port, which exposes swapped selector bits or a quasi-bidirectional pin that drives high strongly. The synchronizer is sampled one edge and two edges after an input change, so a design with one stage or three stages shows a different value. Power-down is applied with wake-mask pins and interrupt-flagged pins held low. A design that gated every pin, or forgot the interrupt exemption, would read 1 on those pins.

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] ANALOG_MASK = 'hF0,
  parameter logic [WIDTH-1:0] WAKE_MASK = 'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fuse_tristate,
  input  logic             pwr_down,
  input  logic [WIDTH-1:0] irq_pin_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] drive_en,
  output logic [WIDTH-1:0] drive_val,
  output logic [WIDTH-1:0] pullup_en,
  output logic [WIDTH-1:0] in_buf_en,
  output logic [WIDTH-1:0] pin_level
);

  localparam logic [1:0] SEL_LATCH = 2'd0;
  localparam logic [1:0] SEL_MODE0 = 2'd1;
  localparam logic [1:0] SEL_MODE1 = 2'd2;
  localparam logic [1:0] SEL_PIN   = 2'd3;

  localparam logic [1:0] MD_QUASI = 2'b00;
  localparam logic [1:0] MD_PUSH  = 2'b01;
  localparam logic [1:0] MD_INPUT = 2'b10;
  localparam logic [1:0] MD_OPEN  = 2'b11;

  logic [WIDTH-1:0] latch_q, mode0_q, mode1_q;
  logic [WIDTH-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      mode0_q <= fuse_tristate ? '1 : ANALOG_MASK;
      mode1_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_LATCH: latch_q <= wr_data;
        SEL_MODE0: mode0_q <= wr_data;
        SEL_MODE1: mode1_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign in_buf_en = {WIDTH{~pwr_down}} | WAKE_MASK | irq_pin_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pin_in | ~in_buf_en;
      sync2_q <= sync1_q;
    end
  end

  assign pin_level = sync2_q;
  assign drive_val = latch_q;

  always_comb begin
    case (rd_sel)
      SEL_LATCH: rd_data = latch_q;
      SEL_MODE0: rd_data = mode0_q;
      SEL_MODE1: rd_data = mode1_q;
      default:   rd_data = sync2_q;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [1:0] mode;
    assign mode = {mode0_q[i], mode1_q[i]};
    assign drive_en[i]  = (mode == MD_PUSH) |
                          (~latch_q[i] & ((mode == MD_QUASI) | (mode == MD_OPEN)));
    assign pullup_en[i] = (mode == MD_QUASI) & latch_q[i];

    assert_quasi_weak_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_QUASI && latch_q[i]) |-> (!drive_en[i] && pullup_en[i]));

    assert_push_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_LATCH && mode == MD_PUSH)
        |=> (drive_en[i] && drive_val[i] == $past(wr_data[i])));

    assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_INPUT) |-> (!drive_en[i] && !pullup_en[i]));

    assert_open_no_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_OPEN) |-> (!pullup_en[i] && (drive_en[i] != drive_val[i])));

    assert_gated_reads_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_buf_en[i] ##1 !in_buf_en[i]) |=> pin_level[i]);

    if (WAKE_MASK[i]) begin : g_wake
      assert_wake_pin_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> in_buf_en[i]);
    end
  end

  assert_mode0_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MODE0) |=> (mode0_q == $past(wr_data)));

  assert_pin_select_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PIN) |=> ($stable(latch_q) && $stable(mode0_q) && $stable(mode1_q)));

endmodule

// File: tb/gpio_mode_port_test.sv
`timescale 1ns/1ps
module gpio_mode_port_test;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, fuse_tristate = 0, pwr_down = 0, wr_en = 0;
  logic [W-1:0] irq_pin_en = '0, wr_data = '0, pin_in = '0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] rd_data, drive_en, drive_val, pullup_en, in_buf_en, pin_level;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_mode_port uut (
    .clk(clk), .rst_n(rst_n), .fuse_tristate(fuse_tristate), .pwr_down(pwr_down),
    .irq_pin_en(irq_pin_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pin_in(pin_in), .drive_en(drive_en),
    .drive_val(drive_val), .pullup_en(pullup_en), .in_buf_en(in_buf_en),
    .pin_level(pin_level)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic fuse);
    @(negedge clk);
    fuse_tristate = fuse;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [W-1:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset_fuse_off();
    do_reset(1'b0);
    rd_chk("R7 mode0 default", 2'd1, 8'hF0);
    rd_chk("R7 mode1 default", 2'd2, 8'h00);
    rd_chk("R8 latch reset", 2'd0, 8'hFF);
    chk("R7 pullup on quasi pins", pullup_en, 8'h0F);
    chk("R7 no strong drive", drive_en, 8'h00);
  endtask

  task automatic t_reset_fuse_on();
    do_reset(1'b1);
    rd_chk("R6 mode0 default", 2'd1, 8'hFF);
    rd_chk("R6 mode1 default", 2'd2, 8'h00);
    chk("R6 no pullup", pullup_en, 8'h00);
    chk("R6 no drive", drive_en, 8'h00);
  endtask

  task automatic t_quasi();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'hA5);
    chk("R1 quasi drive_en", drive_en, 8'h5A);
    chk("R1 quasi pullup", pullup_en, 8'hA5);
    chk("R1 quasi drive_val", drive_val & drive_en, 8'h00);
  endtask

  task automatic t_push();
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd0, 8'h3C);
    chk("R2 push drive_en", drive_en, 8'hFF);
    chk("R2 push drive_val", drive_val, 8'h3C);
    chk("R2 push pullup", pullup_en, 8'h00);
  endtask

  task automatic t_input();
    wr(2'd1, 8'hFF); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    chk("R3 input drive_en", drive_en, 8'h00);
    chk("R3 input pullup", pullup_en, 8'h00);
  endtask

  task automatic t_open();
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h0F);
    chk("R4 open drive_en", drive_en, 8'hF0);
    chk("R4 open drive_val", drive_val & drive_en, 8'h00);
    chk("R4 open pullup", pullup_en, 8'h00);
  endtask

  task automatic t_mixed();
    wr(2'd1, 8'hCC); wr(2'd2, 8'hAA); wr(2'd0, 8'h77);
    chk("R5 mixed drive_en", drive_en, 8'hAA);
    chk("R5 mixed pullup", pullup_en, 8'h11);
    chk("R5 mixed drive_val", drive_val, 8'h77);
    rd_chk("R8 mode0 readback", 2'd1, 8'hCC);
    rd_chk("R8 mode1 readback", 2'd2, 8'hAA);
    rd_chk("R8 latch readback", 2'd0, 8'h77);
    wr(2'd3, 8'h00);
    rd_chk("R8 sel3 write ignored latch", 2'd0, 8'h77);
    rd_chk("R8 sel3 write ignored mode0", 2'd1, 8'hCC);
    rd_chk("R8 sel3 write ignored mode1", 2'd2, 8'hAA);
  endtask

  task automatic t_sync();
    wr(2'd0, 8'hFF);
    pwr_down = 0; irq_pin_en = '0;
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h5A;
    @(negedge clk);
    rd_chk("R9 one edge unchanged", 2'd3, 8'h00);
    @(negedge clk);
    rd_chk("R9 two edges updated", 2'd3, 8'h5A);
    chk("R9 pin_level not latch", pin_level, 8'h5A);
  endtask

  task automatic t_powerdown();
    @(negedge clk);
    pin_in = 8'h00; irq_pin_en = 8'h00; pwr_down = 1;
    #1;
    chk("R10 buffers gated", in_buf_en, 8'h0C);
    repeat (2) @(negedge clk);
    chk("R10 gated pins read one", pin_level, 8'hF3);
    irq_pin_en = 8'h01;
    #1;
    chk("R11 irq pin buffer on", in_buf_en, 8'h0D);
    repeat (2) @(negedge clk);
    chk("R11 irq and wake pins live", pin_level, 8'hF2);
    pwr_down = 0; irq_pin_en = 8'h00;
    repeat (2) @(negedge clk);
    chk("R10 exit restores reads", pin_level, 8'h00);
  endtask

  initial begin
    t_reset_fuse_on();
    t_reset_fuse_off();
    t_quasi();
    t_push();
    t_input();
    t_open();
    t_mixed();
    t_sync();
    t_powerdown();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule